// File: doc/BRIEF.md
# NAND Command Sequencer with Address-Encoded Control

This block sits between a simple word-wide bus and an 8-bit NAND flash device. It has no control registers. Each bus access says what to do through the bits of its own address. A command-phase write names a start opcode, an optional closing opcode with its enable flag, and a count of address bytes. The write data of that access supplies the address bytes. A data-phase access moves one 32-bit word to or from the flash, one byte per strobe. The same data-phase access can also issue a closing opcode after its bytes and can release chip enable once it completes.

Every flash bus cycle has the same fixed strobe shape: a low time of `LOW_W` clocks and a high time of `HIGH_W` clocks. A data strobe never follows a command or address strobe sooner than a guard time set by `GAP_W`. The ready/busy pin is synchronized to the clock. When that pin goes from busy to ready, a sticky flag is set. Software clears the flag and treats it as the device-ready indication.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are high, and `nf_cle`, `nf_ale`, `nf_dq_oe`, `irq_raw` and `bus_ack` are low.
- R2: An access with address bit 19 = 0 is a command phase. Its first flash cycle is a write strobe with `nf_cle`=1 and `nf_ale`=0, carrying the opcode from address bits [10:3]. `nf_cle` and `nf_ale` are never high together.
- R3: After the start opcode, the access issues N write strobes with `nf_ale`=1, where N = address bits [23:21]. The bytes are taken from `bus_wdata` least-significant byte first. N = 0 is legal and issues no address cycle.
- R4: When address bit 20 is 1, a final write strobe with `nf_cle`=1 carries the opcode from address bits [18:11]. When bit 20 is 0, no closing cycle occurs, whatever bits [18:11] hold.
- R5: When N > 4, the access is acknowledged after 4 address bytes. The next bus write supplies the remaining N-4 bytes, least-significant first, followed by the closing opcode if bit 20 was set.
- R6: A data-phase write (bit 19 = 1, `bus_we`=1) issues 4 write strobes with `nf_cle`=`nf_ale`=0. The bytes are taken from `bus_wdata` least-significant byte first.
- R7: A data-phase read issues 4 read strobes and no write strobe. `nf_dq_oe` is low while `nf_re_n` is low. The byte captured on each rising `nf_re_n` fills `bus_rdata` from the least-significant byte upward, and the word is valid together with `bus_ack`.
- R8: A data-phase access with address bit 20 = 1 is followed by one write strobe with `nf_cle`=1, carrying the opcode from address bits [18:11].
- R9: `nf_ce_n` goes low when an access is accepted. It stays low between accesses, and is low whenever a strobe is low. It goes high only when a data-phase access with address bit 21 = 1 completes.
- R10: Every low pulse of `nf_we_n` or `nf_re_n` lasts exactly `LOW_W` clocks.
- R11: The first data strobe that follows a command or address cycle falls no sooner than `HIGH_W`+`GAP_W`+1 clocks after that cycle's rising `nf_we_n`.
- R12: A busy-to-ready transition (rising edge) on `nf_rb` sets `irq_raw`. A falling edge does not set it. `irq_clr` clears it, and a set in the same cycle wins over the clear.
- R13: `bus_ack` is a single-cycle pulse. An access is accepted only while `bus_req` is high and `bus_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 24 | Access address carrying phase and control fields |
| bus_wdata | input | 32 | Write data: address bytes or flash data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Word assembled by a data-phase read |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven onto the flash I/O bus |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_out` |
| nf_dq_in | input | 8 | Byte read from the flash I/O bus |
| nf_rb | input | 1 | Ready/busy pin, 1 = ready |
| irq_clr | input | 1 | Clears `irq_raw` |
| irq_raw | output | 1 | Sticky ready flag |

## Verification
The assertions assume that the bus master holds `bus_req` stable from the moment it raises it until it sees `bus_ack`, and that it drops the request right after. They also assume that, when more than four address bytes are pending, the next request is the continuation write. The bench's access task always raises the request on a falling clock edge and waits for the acknowledge pulse. It lowers the request on the falling edge where the pulse is seen. The only long-address access it issues is immediately followed by its continuation write. Ready/busy changes are applied only while the sequencer is idle, so the synchronizer delay never overlaps an access.

// File: rtl/nas_pkg.sv
package nas_pkg;
  localparam int ADDR_W    = 24;
  localparam int PHASE_BIT = 19;
  localparam int OPS_LSB   = 3;
  localparam int OPE_LSB   = 11;
  localparam int ENDV_BIT  = 20;
  localparam int ACNT_LSB  = 21;
  localparam int ACNT_W    = 3;
  localparam int RELCE_BIT = 21;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_WR   = 2'd2,
    BK_RD   = 2'd3
  } byte_kind_t;

  typedef struct packed {
    logic              data_phase;
    logic              is_read;
    logic [7:0]        op_start;
    logic [7:0]        op_end;
    logic              end_valid;
    logic [ACNT_W-1:0] n_addr;
    logic              rel_ce;
  } acc_t;
endpackage

// File: rtl/nas_decode.sv
module nas_decode
  import nas_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output acc_t              acc
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[OPS_LSB-1:0];

  always_comb begin
    acc            = '0;
    acc.data_phase = addr[PHASE_BIT];
    acc.is_read    = ~we;
    acc.op_start   = addr[OPS_LSB +: 8];
    acc.op_end     = addr[OPE_LSB +: 8];
    acc.end_valid  = addr[ENDV_BIT];
    acc.n_addr     = addr[ACNT_LSB +: ACNT_W];
    acc.rel_ce     = addr[RELCE_BIT];
  end
endmodule

// File: rtl/nas_strobe_engine.sv
module nas_strobe_engine
  import nas_pkg::*;
#(
  parameter int LOW_W  = 2,
  parameter int HIGH_W = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  byte_kind_t kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] dq_in,
  output logic       we_n,
  output logic       re_n,
  output logic       cle,
  output logic       ale,
  output logic       dq_oe,
  output logic [7:0] dq_out,
  output logic [7:0] rbyte,
  output logic       done
);
  localparam int MAXW = (LOW_W > HIGH_W) ? LOW_W : HIGH_W;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [1:0] {EG_IDLE, EG_LOW, EG_HIGH} eg_t;
  eg_t        st_q;
  logic [CW-1:0] cnt_q;
  byte_kind_t kind_q;

  assign done = (st_q == EG_HIGH) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= EG_IDLE;
      cnt_q  <= '0;
      kind_q <= BK_CMD;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      cle    <= 1'b0;
      ale    <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
      rbyte  <= '0;
    end else begin
      case (st_q)
        EG_IDLE: if (start) begin
          kind_q <= kind;
          cle    <= (kind == BK_CMD);
          ale    <= (kind == BK_ADDR);
          dq_out <= wbyte;
          dq_oe  <= (kind != BK_RD);
          we_n   <= (kind == BK_RD);
          re_n   <= (kind != BK_RD);
          cnt_q  <= CW'(LOW_W - 1);
          st_q   <= EG_LOW;
        end
        EG_LOW: begin
          if (cnt_q == '0) begin
            we_n  <= 1'b1;
            re_n  <= 1'b1;
            if (kind_q == BK_RD) rbyte <= dq_in;
            cnt_q <= CW'(HIGH_W - 1);
            st_q  <= EG_HIGH;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        EG_HIGH: begin
          if (cnt_q == '0) begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
            st_q  <= EG_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= EG_IDLE;
      endcase
    end
  end

  // Run-length counters of strobe low time, used by the width checks.
  logic [7:0] we_low_run, re_low_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_run <= '0;
      re_low_run <= '0;
    end else begin
      we_low_run <= we_n ? 8'd0 : we_low_run + 8'd1;
      re_low_run <= re_n ? 8'd0 : re_low_run + 8'd1;
    end
  end

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst) !(cle && ale)); // R2
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(we_n) |-> (we_low_run == 8'(LOW_W))); // R10
  AST_RE_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(re_n) |-> (re_low_run == 8'(LOW_W))); // R10
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst) !re_n |-> !dq_oe); // R7
endmodule

// File: rtl/nas_ready_flag.sv
module nas_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic rb_pin,
  input  logic clr,
  output logic flag
);
  logic rb_s1, rb_s2, rb_q;
  logic went_ready;

  assign went_ready = rb_s2 & ~rb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_s1 <= 1'b1;
      rb_s2 <= 1'b1;
      rb_q  <= 1'b1;
      flag  <= 1'b0;
    end else begin
      rb_s1 <= rb_pin;
      rb_s2 <= rb_s1;
      rb_q  <= rb_s2;
      if (went_ready)  flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst) went_ready |=> flag); // R12
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(flag) |-> ($past(rb_s2) && !$past(rb_q))); // R12
endmodule

// File: rtl/nas_sequencer.sv
module nas_sequencer
  import nas_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int GAP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  acc_t              acc_i,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              ce_n,
  output logic              eng_start,
  output byte_kind_t        eng_kind,
  output logic [7:0]        eng_wbyte,
  input  logic              eng_done,
  input  logic [7:0]        eng_rbyte
);
  localparam int BYTES = WORD_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int GCW   = $clog2(GAP_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_HOLD, ST_DATA, ST_END, ST_FIN
  } st_t;

  st_t               state;
  acc_t              acc_q;
  logic [WORD_W-1:0] wdata_q;
  logic [ACNT_W-1:0] left_q;
  logic [IDX_W-1:0]  idx_q;
  logic              issued_q;
  logic              ack_q;
  logic              ce_n_q;
  logic [GCW-1:0]    gap_q;
  logic              op_active;
  logic              take;

  assign bus_ack = ack_q;
  assign ce_n    = ce_n_q;
  assign take    = bus_req && !ack_q;

  always_comb begin
    eng_kind  = BK_CMD;
    eng_wbyte = 8'h00;
    op_active = 1'b0;
    case (state)
      ST_START: begin
        op_active = 1'b1;
        eng_wbyte = acc_q.op_start;
      end
      ST_ADDR: begin
        op_active = 1'b1;
        eng_kind  = BK_ADDR;
        eng_wbyte = wdata_q[{idx_q, 3'b000} +: 8];
      end
      ST_DATA: begin
        op_active = (gap_q == '0);
        eng_kind  = acc_q.is_read ? BK_RD : BK_WR;
        eng_wbyte = wdata_q[{idx_q, 3'b000} +: 8];
      end
      ST_END: begin
        op_active = 1'b1;
        eng_wbyte = acc_q.op_end;
      end
      default: ;
    endcase
    eng_start = op_active && !issued_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      acc_q    <= '0;
      wdata_q  <= '0;
      left_q   <= '0;
      idx_q    <= '0;
      issued_q <= 1'b0;
      ack_q    <= 1'b0;
      ce_n_q   <= 1'b1;
      gap_q    <= '0;
    end else begin
      ack_q <= 1'b0;
      if (eng_start)      issued_q <= 1'b1;
      else if (eng_done)  issued_q <= 1'b0;

      if (eng_done && (state != ST_DATA)) gap_q <= GCW'(GAP_W);
      else if (gap_q != '0)               gap_q <= gap_q - 1'b1;

      case (state)
        ST_IDLE: if (take) begin
          acc_q   <= acc_i;
          wdata_q <= bus_wdata;
          ce_n_q  <= 1'b0;
          idx_q   <= '0;
          left_q  <= acc_i.n_addr;
          state   <= acc_i.data_phase ? ST_DATA : ST_START;
        end
        ST_START: if (eng_done) begin
          if (left_q != '0)         state <= ST_ADDR;
          else if (acc_q.end_valid) state <= ST_END;
          else                      state <= ST_FIN;
        end
        ST_ADDR: if (eng_done) begin
          left_q <= left_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
          if (left_q == ACNT_W'(1)) begin
            state <= acc_q.end_valid ? ST_END : ST_FIN;
          end else if (idx_q == IDX_W'(BYTES - 1)) begin
            state <= ST_HOLD;
            ack_q <= 1'b1;
          end
        end
        ST_HOLD: if (take) begin
          wdata_q <= bus_wdata;
          idx_q   <= '0;
          state   <= ST_ADDR;
        end
        ST_DATA: if (eng_done) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(BYTES - 1))
            state <= acc_q.end_valid ? ST_END : ST_FIN;
        end
        ST_END: if (eng_done) state <= ST_FIN;
        ST_FIN: begin
          ack_q <= 1'b1;
          if (acc_q.data_phase && acc_q.rel_ce) ce_n_q <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // One capture register per byte lane of the read word.
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= '0;
      else if ((state == ST_DATA) && eng_done && acc_q.is_read && (idx_q == IDX_W'(b)))
        lane_q <= eng_rbyte;
    end
    assign bus_rdata[b*8 +: 8] = lane_q;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst) ack_q |=> !ack_q); // R13
  AST_NO_ACCEPT_ON_ACK: assert property (@(posedge clk) disable iff (rst) (ack_q && state == ST_IDLE) |=> (state == ST_IDLE)); // R13
  AST_DATA_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) (eng_start && state == ST_DATA) |-> (gap_q == '0)); // R11
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nas_pkg::*;
#(
  parameter int LOW_W  = 2,
  parameter int HIGH_W = 2,
  parameter int GAP_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_dq_out,
  output logic              nf_dq_oe,
  input  logic [7:0]        nf_dq_in,
  input  logic              nf_rb,
  input  logic              irq_clr,
  output logic              irq_raw
);
  acc_t       acc;
  logic       eng_start, eng_done;
  byte_kind_t eng_kind;
  logic [7:0] eng_wbyte, eng_rbyte;

  nas_decode u_decode (
    .addr (bus_addr),
    .we   (bus_we),
    .acc  (acc)
  );

  nas_sequencer #(.WORD_W(WORD_W), .GAP_W(GAP_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .acc_i     (acc),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .ce_n      (nf_ce_n),
    .eng_start (eng_start),
    .eng_kind  (eng_kind),
    .eng_wbyte (eng_wbyte),
    .eng_done  (eng_done),
    .eng_rbyte (eng_rbyte)
  );

  nas_strobe_engine #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .start  (eng_start),
    .kind   (eng_kind),
    .wbyte  (eng_wbyte),
    .dq_in  (nf_dq_in),
    .we_n   (nf_we_n),
    .re_n   (nf_re_n),
    .cle    (nf_cle),
    .ale    (nf_ale),
    .dq_oe  (nf_dq_oe),
    .dq_out (nf_dq_out),
    .rbyte  (eng_rbyte),
    .done   (eng_done)
  );

  nas_ready_flag u_rdy (
    .clk    (clk),
    .rst    (rst),
    .rb_pin (nf_rb),
    .clr    (irq_clr),
    .flag   (irq_raw)
  );

  AST_CE_DURING_STROBE: assert property (@(posedge clk) disable iff (rst) (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R9
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst) !(!nf_we_n && !nf_re_n)); // R10
endmodule

// File: tb/nand_addr_seq_tb_top.sv
`timescale 1ns/1ps
module nand_addr_seq_tb_top;
  localparam int LOW_W = 2, HIGH_W = 2, GAP_W = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, bus_req, bus_we, bus_ack, irq_clr, irq_raw, nf_rb;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_out, nf_dq_in;

  nand_addr_seq #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .GAP_W(GAP_W)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
    .nf_rb(nf_rb), .irq_clr(irq_clr), .irq_raw(irq_raw)
  );

  int n_chk = 0, n_bad = 0;
  bit mon_en = 0, finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Flash read model: byte value 0xA0 + number of read strobes completed.
  int rd_idx = 0;
  assign nf_dq_in = 8'hA0 + 8'(rd_idx);
  always @(posedge nf_re_n) if (mon_en) rd_idx++;

  // Log of write strobes, captured on each rising WE.
  logic [7:0] l_dq [64];
  bit l_cle [64], l_ale [64];
  int l_n = 0;
  logic [7:0] e_dq [64];
  bit e_cle [64], e_ale [64];
  int e_n = 0;

  always @(posedge nf_we_n) if (mon_en && l_n < 64) begin
    l_dq[l_n] = nf_dq_out; l_cle[l_n] = nf_cle; l_ale[l_n] = nf_ale; l_n++;
  end

  task automatic clear_logs();
    l_n = 0; e_n = 0;
  endtask

  task automatic exp_cyc(input bit c, input bit a, input logic [7:0] d);
    e_cle[e_n] = c; e_ale[e_n] = a; e_dq[e_n] = d; e_n++;
  endtask

  task automatic compare_log(input string req, input string what);
    bit ok = (l_n == e_n);
    logic [31:0] act = 32'(l_n), exp = 32'(e_n);
    if (ok) begin
      for (int i = 0; i < e_n; i++) begin
        if (ok && (l_dq[i] !== e_dq[i] || l_cle[i] !== e_cle[i] || l_ale[i] !== e_ale[i])) begin
          ok = 0;
          act = {16'(i), 6'd0, l_cle[i], l_ale[i], l_dq[i]};
          exp = {16'(i), 6'd0, e_cle[i], e_ale[i], e_dq[i]};
        end
      end
    end
    check(ok, req, what, act, exp);
  endtask

  // Cycle-level monitors: strobe widths, ack pulse, command-to-data gap.
  int wl = 0, rl = 0, width_bad = 0, ack_bad = 0, since = 0, gap_meas = -1;
  bit ack_prev = 0, prev_we = 1, prev_re = 1, gap_arm = 0;
  always @(negedge clk) if (mon_en) begin
    if (!nf_we_n) wl++; else begin if (wl != 0 && wl != LOW_W) width_bad++; wl = 0; end
    if (!nf_re_n) rl++; else begin if (rl != 0 && rl != LOW_W) width_bad++; rl = 0; end
    if (bus_ack && ack_prev) ack_bad++;
    ack_prev = bus_ack;
    since++;
    if (!prev_we && nf_we_n && (nf_cle || nf_ale)) since = 0;
    if (gap_arm && ((prev_we && !nf_we_n) || (prev_re && !nf_re_n)) && !nf_cle && !nf_ale) begin
      gap_meas = since; gap_arm = 0;
    end
    prev_we = nf_we_n; prev_re = nf_re_n;
  end

  task automatic bus_access(input logic we, input logic [23:0] a, input logic [31:0] d,
                            output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    while (!bus_ack) @(negedge clk);
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  function automatic logic [23:0] cmd_addr(input logic [7:0] s, input logic [7:0] e,
                                           input logic ev, input logic [2:0] n);
    return {n, ev, 1'b0, e, s, 3'b000};
  endfunction

  function automatic logic [23:0] dat_addr(input logic [7:0] e, input logic ev, input logic rel);
    return {2'b00, rel, ev, 1'b1, e, 8'h00, 3'b000};
  endfunction

  // Command-phase vectors: {start, end, end_valid, n_addr, wdata, expected strobe count}
  localparam logic [55:0] VEC [0:5] = '{
    {8'hFF, 8'h00, 1'b0, 3'd0, 32'h0000_0000, 4'd1},
    {8'h70, 8'h00, 1'b0, 3'd0, 32'h1234_5678, 4'd1},
    {8'h90, 8'h00, 1'b0, 3'd1, 32'h0000_0020, 4'd2},
    {8'h60, 8'hD0, 1'b1, 3'd3, 32'h0056_3412, 4'd5},
    {8'h05, 8'hE0, 1'b1, 3'd2, 32'h0000_BEEF, 4'd4},
    {8'h00, 8'h30, 1'b0, 3'd4, 32'h4433_2211, 4'd5}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R13: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst = 1; bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; irq_clr = 0; nf_rb = 1;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe, irq_raw, bus_ack} === 8'b1110_0000,
          "R1", "reset outputs",
          {24'd0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe, irq_raw, bus_ack}, 32'h0000_00E0);
    mon_en = 1; rd_idx = 0; clear_logs();

    // Table walk: R2 start opcode, R3 address bytes, R4 closing opcode
    for (int v = 0; v < 6; v++) begin
      logic [7:0] s, e; logic ev; logic [2:0] n; logic [31:0] d; logic [3:0] xn;
      {s, e, ev, n, d, xn} = VEC[v];
      clear_logs();
      exp_cyc(1, 0, s);
      for (int k = 0; k < int'(n); k++) exp_cyc(0, 1, d[k*8 +: 8]);
      if (ev) exp_cyc(1, 0, e);
      bus_access(1'b1, cmd_addr(s, e, ev, n), d, rd);
      compare_log("R2/R3/R4", $sformatf("vector %0d strobe log", v));
      check(e_n == int'(xn), "R3", $sformatf("vector %0d table count", v), 32'(e_n), 32'(xn));
    end
    // R9: chip enable held between accesses
    check(nf_ce_n === 1'b0, "R9", "CE held after command", 32'(nf_ce_n), 32'd0);

    // R5: five address bytes over two writes
    clear_logs();
    bus_access(1'b1, cmd_addr(8'h80, 8'h10, 1'b1, 3'd5), 32'h4433_2211, rd);
    check(l_n == 5, "R5", "strobes before first ack", 32'(l_n), 32'd5);
    bus_access(1'b1, cmd_addr(8'h80, 8'h10, 1'b1, 3'd5), 32'h0000_0055, rd);
    exp_cyc(1, 0, 8'h80);
    exp_cyc(0, 1, 8'h11); exp_cyc(0, 1, 8'h22); exp_cyc(0, 1, 8'h33); exp_cyc(0, 1, 8'h44);
    exp_cyc(0, 1, 8'h55); exp_cyc(1, 0, 8'h10);
    compare_log("R5", "continued address log");

    // R6 data write, R11 gap after address
    clear_logs();
    bus_access(1'b1, cmd_addr(8'h85, 8'h00, 1'b0, 3'd3), 32'h0003_0201, rd);
    gap_arm = 1; gap_meas = -1;
    bus_access(1'b1, dat_addr(8'h00, 1'b0, 1'b0), 32'hDDCC_BBAA, rd);
    exp_cyc(1, 0, 8'h85); exp_cyc(0, 1, 8'h01); exp_cyc(0, 1, 8'h02); exp_cyc(0, 1, 8'h03);
    exp_cyc(0, 0, 8'hAA); exp_cyc(0, 0, 8'hBB); exp_cyc(0, 0, 8'hCC); exp_cyc(0, 0, 8'hDD);
    compare_log("R6", "data write log");
    check(gap_meas >= HIGH_W + GAP_W + 1, "R11", "address to data gap",
          32'(gap_meas), 32'(HIGH_W + GAP_W + 1));

    // R8: closing opcode after data
    clear_logs();
    bus_access(1'b1, dat_addr(8'h10, 1'b1, 1'b0), 32'h8765_4321, rd);
    exp_cyc(0, 0, 8'h21); exp_cyc(0, 0, 8'h43); exp_cyc(0, 0, 8'h65); exp_cyc(0, 0, 8'h87);
    exp_cyc(1, 0, 8'h10);
    compare_log("R8", "data then closing opcode");

    // R7: reads assemble LSB first
    clear_logs(); rd_idx = 0;
    bus_access(1'b0, dat_addr(8'h00, 1'b0, 1'b0), 32'h0, rd);
    check(rd === 32'hA3A2_A1A0, "R7", "first read word", rd, 32'hA3A2_A1A0);
    check(l_n == 0, "R7", "write strobes during read", 32'(l_n), 32'd0);
    check(nf_ce_n === 1'b0, "R9", "CE held without release flag", 32'(nf_ce_n), 32'd0);
    bus_access(1'b0, dat_addr(8'h00, 1'b0, 1'b1), 32'h0, rd);
    check(rd === 32'hA7A6_A5A4, "R7", "second read word", rd, 32'hA7A6_A5A4);
    check(nf_ce_n === 1'b1, "R9", "CE released by flag", 32'(nf_ce_n), 32'd1);
    bus_access(1'b1, cmd_addr(8'h70, 8'h00, 1'b0, 3'd0), 32'h0, rd);
    check(nf_ce_n === 1'b0, "R9", "CE asserted by new command", 32'(nf_ce_n), 32'd0);

    // R10 widths, R13 ack pulse
    repeat (3) @(negedge clk);
    check(width_bad == 0, "R10", "strobe low width errors", 32'(width_bad), 32'd0);
    check(ack_bad == 0, "R13", "multi-cycle ack pulses", 32'(ack_bad), 32'd0);

    // R12: ready flag
    nf_rb = 0;
    repeat (6) @(negedge clk);
    check(irq_raw === 1'b0, "R12", "flag after busy edge", 32'(irq_raw), 32'd0);
    nf_rb = 1;
    repeat (6) @(negedge clk);
    check(irq_raw === 1'b1, "R12", "flag after ready edge", 32'(irq_raw), 32'd1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    @(negedge clk);
    check(irq_raw === 1'b0, "R12", "flag after clear", 32'(irq_raw), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule